// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Controller

This controller connects a serial flash device to an on-chip bus. It has two modes. In direct mode, a bus read of one 32-bit word is turned into a complete flash read transaction. The controller asserts chip select and sends the read opcode on one line. It then sends a 3-byte address on one, two or four lines, runs a configurable number of idle dummy clocks with the data outputs released, and shifts in four bytes. Chip select is released after every word, so each word is one transaction.

In manual mode, software controls the flash one byte at a time through a small register port. Writing the data register clocks one byte out on the first data line while one byte is captured from the second line. A hold bit in the configuration register keeps chip select asserted between bytes, so software can build multi-byte commands.

The serial clock runs at the system clock divided by an even number, with 2 as the smallest divisor. A late-sample option moves the input capture from the rising serial-clock edge to the falling one, for flash parts whose output arrives slowly at high clock rates. A build-time parameter selects the reset configuration: quad width with opcode EB and 6 dummy clocks, or single width with opcode 03 and no dummy clocks. The reset divider gives half the maximum serial rate.

Top module: `spi_flash_ctrl`

## Requirements
- R1: After reset, `spi_cs_n` is 1 and `spi_sck` is 0, and the configuration register reads back its build default. With the quad default this is 0x000216EB.
- R2: A direct read of byte address A returns the four flash bytes starting at {A[23:2],2'b00}, in little-endian order. The byte at the lowest address appears in bits [7:0].
- R3: A direct read first sends the opcode from config bits [7:0], MSB first, on dq0 for 8 clocks. It then sends the 24-bit address MSB first on the lanes selected by config bits [17:16] (0 = dq0 only, 1 = dq1:dq0, 2 = dq3:dq0, with the highest lane carrying the most significant bit).
- R4: After the address come the dummy clocks set by config bits [11:8], with dq0 released, then the data clocks. The total number of serial clocks is 8 + 24/L + dummy + 32/L, where L is the lane count. In single-lane mode, read data arrives on dq1.
- R5: The serial clock period is 2*(D+1) system clocks, where D is config bits [15:12], and the two half periods are equal. The serial clock stays low while chip select is inactive.
- R6: When config bit 18 is 1, input bits are captured at the falling serial-clock edge. When it is 0, they are captured at the rising edge.
- R7: Chip select is inactive again by the cycle in which `mem_ack` is given.
- R8: No acknowledge is given while a serial transaction is in progress. The bus is stalled until the transaction completes.
- R9: With config bit 19 (manual) set, a write to register 1 sends bits [7:0] MSB first on dq0 and captures one byte from dq1. That byte reads back from register 1 in bits [7:0]. With manual clear, a write to register 1 starts no transaction and leaves the captured byte unchanged.
- R10: If config bit 20 (hold) is set, chip select stays active after a manual byte. Writing the configuration with hold clear releases chip select. If hold is clear during a byte, chip select is released when that byte ends.
- R11: A configuration write to register 0 reads back unchanged from register 0 in bits [20:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | input | 1 | Direct read request, held until acknowledge |
| mem_addr | input | 24 | Byte address of the word to read |
| mem_ack | output | 1 | One-cycle acknowledge with read data |
| mem_rdata | output | 32 | Read word, valid with `mem_ack` |
| reg_req | input | 1 | Register access request, held until acknowledge |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 1 | 0 = configuration, 1 = manual data |
| reg_wdata | input | 32 | Register write data |
| reg_ack | output | 1 | One-cycle register acknowledge |
| reg_rdata | output | 32 | Register read data, valid with `reg_ack` |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_dq_o | output | 4 | Data line output values |
| spi_dq_oe | output | 4 | Data line output enables |
| spi_dq_i | input | 4 | Data line input values |

## Verification
The bench runs direct reads with each lane width at several dummy counts and dividers. The cases include divisor 2, an address at the top of the 16 MB space, and an unaligned byte address. A wrong lane order or byte order would give a word that differs from the flash model's pattern. A wrong address or dummy count would shift the data or change the counted serial clocks.

A slow flash mode in the model changes its output only after the rising edge. Only a controller that captures on the falling edge reads the correct word from it, so a sample-point select that does nothing fails one of the two cases.

Manual mode is checked with chip select held across two bytes and then released. It is also checked when a data write arrives while manual mode is off; a controller that still starts a transfer there would produce serial clocks the model counts.

// File: rtl/spif_pkg.sv
package spif_pkg;
  localparam int DIV_W   = 4;
  localparam int DUMMY_W = 4;
  localparam int CFG_W   = 21;

  localparam logic [1:0] WID_SINGLE = 2'd0;
  localparam logic [1:0] WID_DUAL   = 2'd1;
  localparam logic [1:0] WID_QUAD   = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_XFER
  } spif_state_t;

  // packed: cs_hold is bit 20, opcode is bits [7:0]
  typedef struct packed {
    logic               cs_hold;
    logic               manual;
    logic               late;
    logic [1:0]         width;
    logic [DIV_W-1:0]   div;
    logic [DUMMY_W-1:0] dummy;
    logic [7:0]         opcode;
  } spif_cfg_t;
endpackage

// File: rtl/spif_clkgen.sv
module spif_clkgen #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          sck,
  output logic          rise,
  output logic          fall
);
  logic [DW-1:0] cnt;
  logic          at_lim;

  assign at_lim = run && (cnt == div);
  assign rise   = at_lim && !sck;
  assign fall   = at_lim && sck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (at_lim) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R5
  sck_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cnt != div) |=> $stable(sck));
  // R5
  sck_rest_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sck);
endmodule

// File: rtl/spif_shift.sv
module spif_shift #(
  parameter int SR_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [SR_W-1:0] load_val,
  input  logic            shift,
  input  logic [1:0]      wsh,
  input  logic            cap,
  input  logic [3:0]      din,
  output logic [SR_W-1:0] tx,
  output logic [SR_W-1:0] rx_now
);
  logic [SR_W-1:0] rx_q, rx_sh, tx_sh;

  always_comb begin
    case (wsh)
      2'd0: begin
        rx_sh = {rx_q[SR_W-2:0], din[1]};
        tx_sh = {tx[SR_W-2:0], 1'b0};
      end
      2'd1: begin
        rx_sh = {rx_q[SR_W-3:0], din[1:0]};
        tx_sh = {tx[SR_W-3:0], 2'b00};
      end
      default: begin
        rx_sh = {rx_q[SR_W-5:0], din};
        tx_sh = {tx[SR_W-5:0], 4'h0};
      end
    endcase
  end

  assign rx_now = cap ? rx_sh : rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx   <= '0;
      rx_q <= '0;
    end else begin
      if (load)       tx <= load_val;
      else if (shift) tx <= tx_sh;
      if (cap)        rx_q <= rx_sh;
    end
  end
endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl
  import spif_pkg::*;
#(
  parameter bit DEF_QUAD = 1'b1,
  parameter int DEF_DIV  = 1,
  parameter int ADDR_W   = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_req,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ack,
  output logic [31:0]       mem_rdata,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              reg_ack,
  output logic [31:0]       reg_rdata,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic [3:0]        spi_dq_o,
  output logic [3:0]        spi_dq_oe,
  input  logic [3:0]        spi_dq_i
);
  localparam int DATA_W = 32;
  localparam int SR_W   = ADDR_W + 8;
  localparam int BITS_W = $clog2(SR_W + 1);

  localparam spif_cfg_t CFG_RST = '{
    cs_hold: 1'b0, manual: 1'b0, late: 1'b0,
    width:   DEF_QUAD ? WID_QUAD : WID_SINGLE,
    div:     DIV_W'(DEF_DIV),
    dummy:   DEF_QUAD ? DUMMY_W'(6) : DUMMY_W'(0),
    opcode:  DEF_QUAD ? 8'hEB : 8'h03
  };

  spif_state_t       state;
  spif_cfg_t         cfg, cfg_in;
  logic              cs_act;
  logic [BITS_W-1:0] bits;
  logic [7:0]        rx_byte;
  logic              sck, rise, fall, run, phase_end, cap, load, shift;
  logic              start_dir, start_man, cfg_acc;
  logic [1:0]        wsh, cfg_wsh;
  logic [SR_W-1:0]   load_val, tx, rx_now;

  assign cfg_in  = spif_cfg_t'(reg_wdata[CFG_W-1:0]);
  assign cfg_wsh = (cfg.width == WID_SINGLE) ? 2'd0 :
                   (cfg.width == WID_DUAL)   ? 2'd1 : 2'd2;
  assign wsh     = (state == ST_CMD || state == ST_XFER) ? 2'd0 : cfg_wsh;
  assign run     = (state != ST_IDLE);
  assign phase_end = fall && (bits == BITS_W'(1));
  assign shift   = fall && !phase_end;
  assign cap     = (state == ST_DATA || state == ST_XFER) && (cfg.late ? fall : rise);

  assign start_man = (state == ST_IDLE) && reg_req && !reg_ack && reg_wr && reg_addr && cfg.manual;
  assign cfg_acc   = (state == ST_IDLE) && reg_req && !reg_ack && !start_man;
  assign start_dir = (state == ST_IDLE) && !cfg_acc && !start_man && mem_req && !mem_ack && !cs_act;

  always_comb begin
    load     = 1'b1;
    load_val = '0;
    if (start_dir)
      load_val = {cfg.opcode, {ADDR_W{1'b0}}};
    else if (start_man)
      load_val = {reg_wdata[7:0], {ADDR_W{1'b0}}};
    else if (phase_end && state == ST_CMD)
      load_val = {mem_addr[ADDR_W-1:2], 2'b00, 8'h00};
    else
      load = 1'b0;
  end

  spif_clkgen #(.DW(DIV_W)) clkgen_i (
    .clk(clk), .rst(rst), .run(run), .div(cfg.div),
    .sck(sck), .rise(rise), .fall(fall)
  );

  spif_shift #(.SR_W(SR_W)) shift_i (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .shift(shift),
    .wsh(wsh), .cap(cap), .din(spi_dq_i), .tx(tx), .rx_now(rx_now)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cfg       <= CFG_RST;
      cs_act    <= 1'b0;
      bits      <= '0;
      rx_byte   <= '0;
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      reg_ack   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      mem_ack <= 1'b0;
      reg_ack <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_man) begin
            cs_act <= 1'b1;
            bits   <= BITS_W'(8);
            state  <= ST_XFER;
          end else if (cfg_acc) begin
            if (reg_wr && !reg_addr) begin
              cfg    <= cfg_in;
              cs_act <= cs_act && cfg_in.cs_hold;
            end
            reg_rdata <= reg_addr ? {24'h0, rx_byte} : 32'(cfg);
            reg_ack   <= 1'b1;
          end else if (start_dir) begin
            cs_act <= 1'b1;
            bits   <= BITS_W'(8);
            state  <= ST_CMD;
          end
        end
        default: begin
          if (phase_end) begin
            case (state)
              ST_CMD: begin
                state <= ST_ADDR;
                bits  <= BITS_W'(ADDR_W >> cfg_wsh);
              end
              ST_ADDR: begin
                if (cfg.dummy != '0) begin
                  state <= ST_DUMMY;
                  bits  <= BITS_W'(cfg.dummy);
                end else begin
                  state <= ST_DATA;
                  bits  <= BITS_W'(DATA_W >> cfg_wsh);
                end
              end
              ST_DUMMY: begin
                state <= ST_DATA;
                bits  <= BITS_W'(DATA_W >> cfg_wsh);
              end
              ST_DATA: begin
                state     <= ST_IDLE;
                cs_act    <= 1'b0;
                mem_rdata <= {rx_now[7:0], rx_now[15:8], rx_now[23:16], rx_now[31:24]};
                mem_ack   <= 1'b1;
              end
              default: begin
                state   <= ST_IDLE;
                cs_act  <= cfg.cs_hold;
                rx_byte <= rx_now[7:0];
                reg_ack <= 1'b1;
              end
            endcase
          end else if (fall) begin
            bits <= bits - 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    spi_dq_o  = 4'b1100;
    spi_dq_oe = 4'b1100;
    case (state)
      ST_CMD, ST_XFER: begin
        spi_dq_o[0] = tx[SR_W-1];
        spi_dq_oe   = 4'b1101;
      end
      ST_ADDR: begin
        case (wsh)
          2'd0: begin spi_dq_o[0] = tx[SR_W-1]; spi_dq_oe = 4'b1101; end
          2'd1: begin spi_dq_o[1:0] = tx[SR_W-1 -: 2]; spi_dq_oe = 4'b1111; end
          default: begin spi_dq_o = tx[SR_W-1 -: 4]; spi_dq_oe = 4'b1111; end
        endcase
      end
      ST_DUMMY, ST_DATA: spi_dq_oe = (wsh == 2'd2) ? 4'b0000 : 4'b1100;
      default: ;
    endcase
  end

  assign spi_cs_n = !cs_act;
  assign spi_sck  = sck;

  // R7
  ack_cs_chk: assert property (@(posedge clk) disable iff (rst)
    mem_ack |-> spi_cs_n);
  // R8
  busy_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (!mem_ack && !reg_ack));
  // R4
  dummy_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(spi_sck) && state == ST_DUMMY) |-> !spi_dq_oe[0]);
  // R10
  hold_cs_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(state == ST_XFER) && state == ST_IDLE && cfg.cs_hold) |-> !spi_cs_n);
endmodule

// File: tb/spi_flash_ctrl_tb.sv
module spi_flash_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req = 1'b0;
  logic [23:0] mem_addr = '0;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        reg_req = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ack;
  logic [31:0] reg_rdata;
  logic        spi_cs_n, spi_sck;
  logic [3:0]  spi_dq_o, spi_dq_oe, spi_dq_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_flash_ctrl dut_i (
    .clk(clk), .rst(rst),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_ack(reg_ack), .reg_rdata(reg_rdata),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_dq_o(spi_dq_o), .spi_dq_oe(spi_dq_oe),
    .spi_dq_i(spi_dq_i)
  );

  // ---------------- behavioural flash responder ----------------
  logic [7:0]  m_op = 8'hEB;
  int          m_w = 4, m_dummy = 6;
  bit          slow = 1'b0;
  int          rises = 0;
  logic [7:0]  f_op = '0;
  logic [23:0] f_addr = '0;
  logic [3:0]  fl_o = '0;
  logic        cs_q = 1'b1, sck_q = 1'b0;

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return 8'(a * 29 + 23);
  endfunction

  function automatic logic [3:0] out_for(input int n);
    int k, p, sh;
    logic [7:0] b;
    logic [3:0] v;
    if (n >= 8 && f_op == m_op) begin
      k = n - (8 + 24 / m_w + m_dummy);
      if (k < 0) return 4'h0;
      p  = k * m_w;
      b  = fbyte(f_addr + 24'(p / 8));
      sh = 8 - (p % 8) - m_w;
      v  = 4'((b >> sh) & ((1 << m_w) - 1));
      return (m_w == 1) ? {2'b00, v[0], 1'b0} : v;
    end
    b = 8'h5A + 8'(n / 8);
    return {2'b00, b[7 - (n % 8)], 1'b0};
  endfunction

  always @(spi_cs_n or spi_sck) begin
    if (cs_q && !spi_cs_n) begin
      rises  = 0;
      f_op   = '0;
      f_addr = '0;
      fl_o   = out_for(0);
    end else if (!spi_cs_n && !sck_q && spi_sck) begin
      if (rises < 8)
        f_op = {f_op[6:0], spi_dq_o[0]};
      else if (f_op == m_op && rises < 8 + 24 / m_w)
        f_addr = (f_addr << m_w) | 24'(spi_dq_o & 4'((1 << m_w) - 1));
      rises = rises + 1;
      if (slow) fl_o = out_for(rises - 1);
    end else if (!spi_cs_n && sck_q && !spi_sck) begin
      if (!slow) fl_o = out_for(rises);
    end
    cs_q  = spi_cs_n;
    sck_q = spi_sck;
  end

  for (genvar i = 0; i < 4; i++) begin : g_dq
    assign spi_dq_i[i] = spi_dq_oe[i] ? spi_dq_o[i] : fl_o[i];
  end

  // period and stall monitors, sampled away from the active edge
  int cyc = 0, last_rise = 0, period = 0, ack_in_tx = 0;
  logic mon_sck = 1'b0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (spi_sck && !mon_sck) begin
      period    = cyc - last_rise;
      last_rise = cyc;
    end
    mon_sck = spi_sck;
    if (!spi_cs_n && mem_ack) ack_in_tx = ack_in_tx + 1;
  end

  // ---------------- helpers ----------------
  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcfg(input bit hold, input bit man, input bit late,
      input logic [1:0] w, input logic [3:0] div, input logic [3:0] dmy, input logic [7:0] op);
    return {11'h0, hold, man, late, w, div, dmy, op};
  endfunction

  task automatic reg_access(input bit wr, input bit a, input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    reg_req = 1'b1; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    do @(negedge clk); while (!reg_ack);
    rd = reg_rdata;
    reg_req = 1'b0;
  endtask

  task automatic mem_read(input logic [23:0] a, output logic [31:0] d);
    @(negedge clk);
    mem_req = 1'b1; mem_addr = a;
    do @(negedge clk); while (!mem_ack);
    d = mem_rdata;
    mem_req = 1'b0;
  endtask

  // vector: {width[1:0], dummy[3:0], div[3:0], late, addr[23:0]}
  localparam int NV = 6;
  localparam logic [34:0] VEC [NV] = '{
    {2'd0, 4'd0, 4'd0, 1'b0, 24'h000010},
    {2'd1, 4'd4, 4'd1, 1'b0, 24'h123456},
    {2'd2, 4'd6, 4'd2, 1'b1, 24'hABCDEC},
    {2'd2, 4'd0, 4'd0, 1'b0, 24'hFFFFFC},
    {2'd0, 4'd8, 4'd3, 1'b1, 24'h000001},
    {2'd1, 4'd0, 4'd0, 1'b1, 24'h7FFFF8}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd, exp;
    logic [23:0] al;
    int saved;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 cs_n", 32'(spi_cs_n), 32'd1);
    check("R1 sck", 32'(spi_sck), 32'd0);
    reg_access(1'b0, 1'b0, 32'h0, rd);
    check("R1 cfg default", rd, 32'h000216EB);
    // R11 readback
    reg_access(1'b1, 1'b0, mkcfg(0, 0, 1, 2'd1, 4'd5, 4'd9, 8'h3C), rd);
    reg_access(1'b0, 1'b0, 32'h0, rd);
    check("R11 cfg readback", rd, mkcfg(0, 0, 1, 2'd1, 4'd5, 4'd9, 8'h3C));

    for (int i = 0; i < NV; i++) begin
      logic [1:0] w; logic [3:0] dmy, div; logic late; logic [23:0] a; logic [7:0] op;
      {w, dmy, div, late, a} = VEC[i];
      op = 8'h0B + 8'(i);
      m_op = op; m_dummy = int'(dmy); m_w = (w == 0) ? 1 : (w == 1) ? 2 : 4; slow = 1'b0;
      reg_access(1'b1, 1'b0, mkcfg(0, 0, late, w, div, dmy, op), rd);
      mem_read(a, rd);
      al  = {a[23:2], 2'b00};
      exp = {fbyte(al + 3), fbyte(al + 2), fbyte(al + 1), fbyte(al)};
      check("R2 read word", rd, exp);
      check("R3 opcode seen", 32'(f_op), 32'(op));
      check("R3 address seen", 32'(f_addr), 32'(al));
      check("R4 clock count", 32'(rises), 32'(8 + 24 / m_w + m_dummy + 32 / m_w));
      check("R5 sck period", 32'(period), 32'(2 * (int'(div) + 1)));
      check("R7 cs released", 32'(spi_cs_n), 32'd1);
    end

    // R6 sample point: slow flash output valid only after the rising edge
    m_op = 8'h03; m_w = 1; m_dummy = 0; slow = 1'b1;
    al  = 24'h004440;
    exp = {fbyte(al + 3), fbyte(al + 2), fbyte(al + 1), fbyte(al)};
    reg_access(1'b1, 1'b0, mkcfg(0, 0, 1, 2'd0, 4'd1, 4'd0, 8'h03), rd);
    mem_read(al, rd);
    check("R6 late sample correct", rd, exp);
    reg_access(1'b1, 1'b0, mkcfg(0, 0, 0, 2'd0, 4'd1, 4'd0, 8'h03), rd);
    mem_read(al, rd);
    n_chk++;
    if (rd === exp) begin
      n_fail++;
      $display("FAIL R6 early sample actual=%h expected=not %h", rd, exp);
    end
    slow = 1'b0;

    // R8 no acknowledge during any transaction so far
    check("R8 ack while cs active", 32'(ack_in_tx), 32'd0);

    // R9/R10 manual mode with chip select held
    reg_access(1'b1, 1'b0, mkcfg(1, 1, 0, 2'd0, 4'd1, 4'd0, 8'h03), rd);
    reg_access(1'b1, 1'b1, 32'h9F, rd);
    check("R9 byte sent", 32'(f_op), 32'h9F);
    reg_access(1'b0, 1'b1, 32'h0, rd);
    check("R9 byte captured", rd, 32'h5A);
    check("R10 cs held", 32'(spi_cs_n), 32'd0);
    reg_access(1'b1, 1'b1, 32'h00, rd);
    reg_access(1'b0, 1'b1, 32'h0, rd);
    check("R10 second byte same select", rd, 32'h5B);
    check("R9 clocks for two bytes", 32'(rises), 32'd16);
    reg_access(1'b1, 1'b0, mkcfg(0, 1, 0, 2'd0, 4'd1, 4'd0, 8'h03), rd);
    @(negedge clk);
    check("R10 release by config", 32'(spi_cs_n), 32'd1);
    reg_access(1'b1, 1'b1, 32'hC3, rd);
    @(negedge clk);
    check("R10 no hold releases", 32'(spi_cs_n), 32'd1);
    check("R9 new select byte", 32'(f_op), 32'hC3);

    // R9 data write ignored when manual is off
    reg_access(1'b1, 1'b0, mkcfg(0, 0, 0, 2'd0, 4'd1, 4'd0, 8'h03), rd);
    saved = rises;
    reg_access(1'b1, 1'b1, 32'h55, rd);
    repeat (20) @(negedge clk);
    check("R9 ignored no clocks", 32'(rises), 32'(saved));
    check("R9 ignored cs idle", 32'(spi_cs_n), 32'd1);
    reg_access(1'b0, 1'b1, 32'h0, rd);
    check("R9 ignored byte kept", rd, 32'h5A);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule